// File: doc/BRIEF.md
# Printer Port Interrupt Controller

This block raises interrupts for a parallel printer port. A host reads and writes one 8-bit interrupt control and status register over a simple synchronous register interface: a one-cycle write strobe with write data, and read data that always shows the current register value. The printer's acknowledge and fault lines are asynchronous. Each one passes through a synchronizer and then an edge detector. Detected events are held in write-one-to-clear pending flags.

Software sets the edge on acknowledge that counts as an event. A fault event is always a falling edge of the fault line. When interrupts are enabled and any flag is pending, the block asserts an interrupt request and drives the programmed 3-bit priority level next to it. The block does not produce vectors, does not daisy-chain and does not arbitrate between levels. The register interface carries no stream of data, so it has no valid/ready handshake. A write always takes effect on the clock edge that samples it.

Top module: `prn_irq_ctrl`

## Requirements
- R1: Reset clears all eight bits of the register and deasserts the request. `reg_rdata` reads 0x00 and `irq_req` is 0.
- R2: Bits 2:0 hold the interrupt level. A write stores them, a read returns them, and they appear on `irq_level` at all times.
- R3: Bit 3 is the interrupt enable and is readable and writable. `irq_req` equals bit 3 AND bit 7.
- R4: Bit 4 selects the acknowledge polarity and is readable and writable. When it is 1, a falling edge of `ack_in` sets bit 5. When it is 0, a rising edge sets bit 5 and a falling edge does not. The edge is taken after a two-flop synchronizer, so the flag becomes visible on the third rising clock edge after the input changes.
- R5: Bit 5 is the acknowledge pending flag. A write with bit 5 = 1 clears it. A write with bit 3 = 0 also clears it.
- R6: Bit 6 is the fault pending flag. Only a falling edge of `fault_in` sets it; a rising edge does not. A write with bit 6 = 1 clears it. A write with bit 3 = 0 does not clear it.
- R7: Bit 7 is read-only and equals bit 5 OR bit 6. Write data in bits 7:5 is never stored. Writing 0 to bit 5 or bit 6 leaves that flag unchanged, and writing 1 to bit 7 changes nothing.
- R8: When an event and a clear reach the same flag in the same cycle, the flag ends up set.
- R9: A pending fault does not raise `irq_req` while bit 3 is 0. Setting bit 3 afterwards raises `irq_req` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register value |
| ack_in | input | 1 | Asynchronous acknowledge from the printer |
| fault_in | input | 1 | Asynchronous fault from the printer |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed interrupt level |

## Verification
Every flag and control bit of this block can be read on `reg_rdata`, so a wrong internal state is visible at the next read. A flag that sets on the wrong polarity shows the wrong value three clock edges after the input changes. A clear that hits the wrong flag shows up on the edge that samples the write. Errors in the summary bit or in the enable gating appear on `irq_req` in the same cycle as the register value that causes them. The bench therefore reads the register back after every stimulus and compares the result with a model computed from the written values and the edges it applied.

// File: rtl/prn_irq_pkg.sv
package prn_irq_pkg;
  localparam int REG_W     = 8;
  localparam int LEVEL_W   = 3;
  localparam int BIT_EN    = 3;
  localparam int BIT_POL   = 4;
  localparam int BIT_ACKF  = 5;
  localparam int BIT_FLTF  = 6;
  localparam int BIT_SUM   = 7;
  localparam logic [REG_W-1:0] STORE_MASK = 8'h1F;
  localparam int N_LINES   = 2;
  localparam int LINE_ACK  = 0;
  localparam int LINE_FLT  = 1;
endpackage

// File: rtl/prn_irq_sync.sv
module prn_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              sync_w;

  assign sync_w = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= sync_w;
    end
  end

  assign rise_o = sync_w & ~prev_q;
  assign fall_o = ~sync_w & prev_q;
endmodule

// File: rtl/prn_irq_flag.sv
module prn_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/prn_irq_ctrl.sv
module prn_irq_ctrl
  import prn_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               ack_in,
  input  logic               fault_in,
  output logic               irq_req,
  output logic [LEVEL_W-1:0] irq_level
);
  logic [REG_W-1:0]   store_q;
  logic [N_LINES-1:0] line_in, line_rise, line_fall;
  logic               ack_evt, fault_evt;
  logic               ack_clr, fault_clr;
  logic               ack_flag, fault_flag, summary;

  assign line_in[LINE_ACK] = ack_in;
  assign line_in[LINE_FLT] = fault_in;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    prn_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (line_in[g]),
      .rise_o   (line_rise[g]),
      .fall_o   (line_fall[g])
    );
  end

  // Stored control bits: level, enable, polarity.
  always_ff @(posedge clk) begin
    if (!rst_n)      store_q <= '0;
    else if (reg_wr) store_q <= reg_wdata & STORE_MASK;
  end

  assign ack_evt   = store_q[BIT_POL] ? line_fall[LINE_ACK] : line_rise[LINE_ACK];
  assign fault_evt = line_fall[LINE_FLT];
  assign ack_clr   = reg_wr & (reg_wdata[BIT_ACKF] | ~reg_wdata[BIT_EN]);
  assign fault_clr = reg_wr & reg_wdata[BIT_FLTF];

  prn_irq_flag u_ack_flag (
    .clk(clk), .rst_n(rst_n), .set_i(ack_evt), .clr_i(ack_clr), .flag_o(ack_flag)
  );
  prn_irq_flag u_fault_flag (
    .clk(clk), .rst_n(rst_n), .set_i(fault_evt), .clr_i(fault_clr), .flag_o(fault_flag)
  );

  assign summary   = ack_flag | fault_flag;
  assign reg_rdata = store_q | ({summary, fault_flag, ack_flag} << BIT_ACKF);
  assign irq_req   = store_q[BIT_EN] & summary;
  assign irq_level = store_q[LEVEL_W-1:0];
endmodule

// File: rtl/prn_irq_chk.sv
module prn_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq_req,
  input logic [2:0] irq_level,
  input logic       ack_evt,
  input logic       fault_evt
);
  assert_level_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == reg_rdata[2:0]);

  assert_req_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (reg_rdata[3] & (reg_rdata[5] | reg_rdata[6])));

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[4:0] == $past(reg_wdata[4:0]));

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_wdata[5] || !reg_wdata[3]) && !ack_evt) |=> !reg_rdata[5]);

  assert_fault_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[6] && !(reg_wr && reg_wdata[6])) |=> reg_rdata[6]);

  assert_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] == (reg_rdata[5] | reg_rdata[6]));

  assert_bit7_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[7] && !reg_rdata[5] && !reg_rdata[6] && !ack_evt && !fault_evt)
    |=> !reg_rdata[7]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt || fault_evt) |=> reg_rdata[7]);
endmodule

bind prn_irq_ctrl prn_irq_chk u_prn_irq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_req   (irq_req),
  .irq_level (irq_level),
  .ack_evt   (ack_evt),
  .fault_evt (fault_evt)
);

// File: tb/prn_irq_ctrl_bench.sv
module prn_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ack_in = 1'b0;
  logic       fault_in = 1'b1;
  logic       irq_req;
  logic [2:0] irq_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prn_irq_ctrl u_prn_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_in(ack_in), .fault_in(fault_in),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Register read plus request check against a model of bits 7:0.
  task automatic chk_reg(input string tag, input logic [7:0] exp);
    chk(tag, reg_rdata, exp);
    chk(tag, {7'b0, irq_req}, {7'b0, exp[3] & exp[7]});
    chk(tag, {5'b0, irq_level}, {5'b0, exp[2:0]});
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] mk(input logic [4:0] ctl, input logic a, input logic f);
    return {a | f, f, a, ctl};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk_reg("R1 reset", 8'h00);
    rst_n = 1'b1;
    settle();
    chk_reg("R1 after release", 8'h00);

    // R2 R3 R4: sweep every stored control combination.
    for (int v = 0; v < 32; v++) begin
      wr(8'(v));
      chk_reg("R2 R3 R4 store sweep", 8'(v));
    end

    // R4 R5: acknowledge polarity by enable.
    for (int pol = 0; pol < 2; pol++) begin
      for (int en = 0; en < 2; en++) begin
        logic [4:0] ctl;
        ctl = 5'(pol * 16 + en * 8 + 5);
        wr({3'b011, ctl});
        ack_in = 1'b1;
        settle();
        chk_reg("R4 ack rise", mk(ctl, pol == 0, 1'b0));
        wr({3'b001, ctl});
        chk_reg("R5 w1c ack", mk(ctl, 1'b0, 1'b0));
        ack_in = 1'b0;
        settle();
        chk_reg("R4 ack fall", mk(ctl, pol == 1, 1'b0));
        wr({3'b011, ctl});
      end
    end

    // R4 latency: flag appears on the third rising edge.
    wr(8'h08);
    @(negedge clk) ack_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_reg("R4 not yet after two edges", mk(5'h08, 1'b0, 1'b0));
    @(negedge clk);
    chk_reg("R4 set after three edges", mk(5'h08, 1'b1, 1'b0));

    // R7: writing zero to flag bits and one to bit 7 keeps the flag.
    wr(8'h88);
    chk_reg("R7 bit7 write inert", mk(5'h08, 1'b1, 1'b0));
    // R5: disabling clears the ack flag.
    wr(8'h00);
    chk_reg("R5 disable clears ack", mk(5'h00, 1'b0, 1'b0));
    ack_in = 1'b0;
    settle();

    // R6 R9: fault while disabled.
    fault_in = 1'b0;
    settle();
    chk_reg("R6 fault fall sets, R9 no req", mk(5'h02, 1'b0, 1'b1) & 8'hFD);
    wr(8'h0B);
    chk_reg("R9 enable raises req", mk(5'h0B, 1'b0, 1'b1));
    wr(8'h03);
    chk_reg("R6 disable keeps fault", mk(5'h03, 1'b0, 1'b1));
    wr(8'h83);
    chk_reg("R7 bit7 does not clear", mk(5'h03, 1'b0, 1'b1));
    wr(8'h43);
    chk_reg("R6 w1c fault", mk(5'h03, 1'b0, 1'b0));
    fault_in = 1'b1;
    settle();
    chk_reg("R6 fault rise ignored", mk(5'h03, 1'b0, 1'b0));

    // R8: event and clear in the same cycle.
    wr(8'h08);
    @(negedge clk) ack_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = 8'h28;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
    chk_reg("R8 ack set wins", mk(5'h08, 1'b1, 1'b0));
    wr(8'h28);
    @(negedge clk) fault_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = 8'h48;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
    chk_reg("R8 fault set wins", mk(5'h08, 1'b0, 1'b1));

    // R1: reset in the middle of activity.
    rst_n = 1'b0;
    @(negedge clk);
    chk_reg("R1 mid reset", 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule